// File: doc/BRIEF.md
# Received Word Half-Word Readout with Retransmit Copy

This block sits behind a serial receive shifter. When the shifter finishes a 32-bit word it pulses a word-valid strobe, and the block captures the word and pulls an active-low ready flag low. A host on a 16-bit bus then reads the word as two halves. A half-select input picks the half and a read strobe places that half on the bus. An output-enable signal stands in for the tri-state control, so the bus is only driven while the strobe is high. Once both halves of the word have been read, the ready flag returns high.

The block also has a retransmit copy path. Two load strobes, sampled together with the read strobe, copy the half currently on the bus into the write port of a transmit FIFO. The first load strobe writes the first half-word of a pair. The second load strobe writes the closing half-word and marks the FIFO word complete. The closing half is only accepted after an opening half for the same received word. A closing strobe out of order raises a sticky order-error flag instead of writing. A master reset clears the held word, the ready flag, the pairing state and the error flag.

Top module: `rx_halfword_readout`

## Requirements
- R1: A one-cycle `word_valid` pulse captures `word_in`, and `ready_n` is 0 from the next clock edge.
- R2: While `rd_en` is 1, `bus_data` shows bits 15:0 of the held word when `half_sel` is 0 and bits 31:16 when `half_sel` is 1, in the same cycle, with `bus_oe` at 1.
- R3: While `rd_en` is 0, `bus_oe` is 0 and `bus_data` is all zeros.
- R4: The halves may be read in either order. `ready_n` stays 0 after a read of only one half, and it returns to 1 at the edge that samples the read completing both halves.
- R5: `rd_en` with `load_lo` (and `load_hi` at 0) gives `fifo_we`=1 at the next edge, with `fifo_wdata` equal to the bus half and `fifo_word_done`=0. Load strobes while `rd_en` is 0 write nothing.
- R6: `rd_en` with `load_hi` (and `load_lo` at 0), following an accepted `load_lo` for the same word, gives `fifo_we`=1, `fifo_wdata` equal to the bus half, and `fifo_word_done`=1 at the next edge.
- R7: `load_hi` with no prior opening half pending, or `load_lo` and `load_hi` asserted together, writes nothing and sets `order_err` at the next edge. `order_err` then stays 1 until a reset.
- R8: `mreset` (like `rst`) gives `ready_n`=1, `order_err`=0 and `fifo_we`=0 at the next edge, clears the held word to zero, and drops any pending opening half.
- R9: A new `word_valid` cancels a pending opening half, so a following `load_hi` counts as out of order under R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mreset | input | 1 | Synchronous master reset, same effect as rst |
| word_in | input | 32 | Completed word from the receive shifter |
| word_valid | input | 1 | One-cycle pulse when word_in is complete |
| half_sel | input | 1 | 0 selects bits 15:0, 1 selects bits 31:16 |
| rd_en | input | 1 | Read strobe that places the selected half on the bus |
| load_lo | input | 1 | Opening-half copy strobe into the transmit FIFO |
| load_hi | input | 1 | Closing-half copy strobe into the transmit FIFO |
| ready_n | output | 1 | Active-low word-ready flag |
| bus_data | output | 16 | Host bus data |
| bus_oe | output | 1 | Bus drive enable (0 means high impedance) |
| fifo_we | output | 1 | Transmit FIFO write enable |
| fifo_wdata | output | 16 | Transmit FIFO write data |
| fifo_word_done | output | 1 | Marks the write that completes a FIFO word |
| order_err | output | 1 | Sticky out-of-order closing-half flag |

## Verification
The bus data and `bus_oe` are combinational from the read strobe and are due in the same cycle. `ready_n`, the FIFO write outputs and `order_err` are registered and are due one edge after the strobe that causes them. The bench changes inputs 1 ns after a rising edge and checks the bus 1 ns after that. It checks registered results 1 ns after the following rising edge, before any new stimulus is applied. A sweep over computed words covers both read orders and the retransmit pair, and dedicated sequences cover the out-of-order cases and the resets.

// File: rtl/rxrd_pkg.sv
package rxrd_pkg;
    localparam int WORD_W = 32;
    localparam int HALF_W = WORD_W / 2;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [HALF_W-1:0] half_t;

    typedef enum logic {
        HALF_LO = 1'b0,
        HALF_HI = 1'b1
    } half_sel_e;

    typedef struct packed {
        logic hi;
        logic lo;
    } rd_mask_t;

    typedef struct packed {
        logic  we;
        logic  done;
        half_t data;
    } fifo_wr_t;

    function automatic half_t pick_half(word_t w, half_sel_e s);
        return (s == HALF_HI) ? w[WORD_W-1:HALF_W] : w[HALF_W-1:0];
    endfunction

    function automatic rd_mask_t mark_read(rd_mask_t m, half_sel_e s);
        rd_mask_t r;
        r = m;
        if (s == HALF_HI) r.hi = 1'b1;
        else              r.lo = 1'b1;
        return r;
    endfunction
endpackage

// File: rtl/rxrd_hold.sv
module rxrd_hold
    import rxrd_pkg::*;
(
    input  logic      clk,
    input  logic      clr,
    input  logic      word_valid,
    input  word_t     word_in,
    input  logic      rd_en,
    input  half_sel_e half_sel,
    output word_t     held,
    output logic      have_word
);
    rd_mask_t mask_q;
    rd_mask_t mask_nx;

    always_comb mask_nx = mark_read(mask_q, half_sel);

    always_ff @(posedge clk) begin
        if (clr) begin
            held      <= '0;
            have_word <= 1'b0;
            mask_q    <= '0;
        end else if (word_valid) begin
            held      <= word_in;
            have_word <= 1'b1;
            mask_q    <= '0;
        end else if (rd_en && have_word) begin
            if (mask_nx.lo && mask_nx.hi) begin
                have_word <= 1'b0;
                mask_q    <= '0;
            end else begin
                mask_q    <= mask_nx;
            end
        end
    end

    assert_capture_R1: assert property (@(posedge clk) disable iff (clr)
        word_valid |=> (have_word && held == $past(word_in)));

    assert_hold_idle_R4: assert property (@(posedge clk) disable iff (clr)
        (have_word && !word_valid && !rd_en) |=> have_word);
endmodule

// File: rtl/rxrd_repeat.sv
module rxrd_repeat
    import rxrd_pkg::*;
(
    input  logic     clk,
    input  logic     clr,
    input  logic     new_word,
    input  logic     rd_en,
    input  logic     load_lo,
    input  logic     load_hi,
    input  half_t    bus_half,
    output fifo_wr_t wr,
    output logic     order_err
);
    logic lo_pend;

    always_ff @(posedge clk) begin
        if (clr) begin
            wr        <= '0;
            lo_pend   <= 1'b0;
            order_err <= 1'b0;
        end else begin
            wr.we   <= 1'b0;
            wr.done <= 1'b0;
            if (rd_en) begin
                unique case ({load_hi, load_lo})
                    2'b01: begin
                        wr.we   <= 1'b1;
                        wr.data <= bus_half;
                        lo_pend <= 1'b1;
                    end
                    2'b10: begin
                        if (lo_pend) begin
                            wr.we   <= 1'b1;
                            wr.done <= 1'b1;
                            wr.data <= bus_half;
                            lo_pend <= 1'b0;
                        end else begin
                            order_err <= 1'b1;
                        end
                    end
                    2'b11:   order_err <= 1'b1;
                    default: ;
                endcase
            end
            if (new_word) lo_pend <= 1'b0;
        end
    end

    assert_done_with_write_R6: assert property (@(posedge clk) disable iff (clr)
        wr.done |-> wr.we);

    assert_write_needs_strobe_R5: assert property (@(posedge clk) disable iff (clr)
        wr.we |-> $past(rd_en));

    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (clr)
        order_err |=> order_err);

    assert_hi_first_R7: assert property (@(posedge clk) disable iff (clr)
        (rd_en && load_hi && !load_lo && !lo_pend) |=> (!wr.we && order_err));
endmodule

// File: rtl/rx_halfword_readout.sv
module rx_halfword_readout
    import rxrd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              mreset,
    input  logic [WORD_W-1:0] word_in,
    input  logic              word_valid,
    input  logic              half_sel,
    input  logic              rd_en,
    input  logic              load_lo,
    input  logic              load_hi,
    output logic              ready_n,
    output logic [HALF_W-1:0] bus_data,
    output logic              bus_oe,
    output logic              fifo_we,
    output logic [HALF_W-1:0] fifo_wdata,
    output logic              fifo_word_done,
    output logic              order_err
);
    logic      clr;
    word_t     held;
    logic      have_word;
    half_t     sel_half;
    half_sel_e sel_e;
    fifo_wr_t  wr;

    assign clr   = rst | mreset;
    assign sel_e = half_sel_e'(half_sel);

    rxrd_hold u_hold (
        .clk        (clk),
        .clr        (clr),
        .word_valid (word_valid),
        .word_in    (word_in),
        .rd_en      (rd_en),
        .half_sel   (sel_e),
        .held       (held),
        .have_word  (have_word)
    );

    assign sel_half = pick_half(held, sel_e);

    rxrd_repeat u_rep (
        .clk       (clk),
        .clr       (clr),
        .new_word  (word_valid),
        .rd_en     (rd_en),
        .load_lo   (load_lo),
        .load_hi   (load_hi),
        .bus_half  (sel_half),
        .wr        (wr),
        .order_err (order_err)
    );

    assign ready_n        = ~have_word;
    assign bus_oe         = rd_en;
    assign bus_data       = rd_en ? sel_half : '0;
    assign fifo_we        = wr.we;
    assign fifo_wdata     = wr.data;
    assign fifo_word_done = wr.done;

    assert_mreset_R8: assert property (@(posedge clk) disable iff (rst)
        mreset |=> (ready_n && !order_err && !fifo_we));

    assert_bus_quiet_R3: assert property (@(posedge clk) disable iff (clr)
        !bus_oe |-> (bus_data == '0));
endmodule

// File: tb/rx_halfword_readout_test.sv
module rx_halfword_readout_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mreset = 1'b0;
    logic [31:0] word_in = '0;
    logic        word_valid = 1'b0;
    logic        half_sel = 1'b0;
    logic        rd_en = 1'b0;
    logic        load_lo = 1'b0;
    logic        load_hi = 1'b0;
    logic        ready_n;
    logic [15:0] bus_data;
    logic        bus_oe;
    logic        fifo_we;
    logic [15:0] fifo_wdata;
    logic        fifo_word_done;
    logic        order_err;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    rx_halfword_readout uut (.*);

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic edge_step();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        word_valid = 0; rd_en = 0; load_lo = 0; load_hi = 0; mreset = 0;
    endtask

    task automatic give_word(logic [31:0] w);
        word_in = w; word_valid = 1;
        edge_step();
        idle();
        check(ready_n == 1'b0, "R1 ready_n", {31'd0, ready_n}, 32'd0);
    endtask

    // read one half, optionally with load strobes; checks bus in-cycle
    task automatic read_half(logic [31:0] w, logic sel, logic ll, logic lh);
        half_sel = sel; rd_en = 1; load_lo = ll; load_hi = lh;
        #1;
        check(bus_oe == 1'b1, "R2 bus_oe", {31'd0, bus_oe}, 32'd1);
        check(bus_data == (sel ? w[31:16] : w[15:0]), "R2 bus_data",
              {16'd0, bus_data}, {16'd0, (sel ? w[31:16] : w[15:0])});
        edge_step();
        idle();
    endtask

    initial begin
        logic [31:0] w;
        edge_step(); edge_step();
        rst = 0;
        check(ready_n == 1'b1, "R8 reset ready_n", {31'd0, ready_n}, 32'd1);
        check(bus_oe == 1'b0, "R3 reset bus_oe", {31'd0, bus_oe}, 32'd0);
        check(fifo_we == 1'b0 && order_err == 1'b0, "R8 reset flags",
              {30'd0, fifo_we, order_err}, 32'd0);

        for (int i = 0; i < 9; i++) begin
            w = (32'h9E37_79B9 * (i + 1)) ^ (32'h0101_0101 << i);
            give_word(w);
            if (i % 3 == 2) begin
                read_half(w, 0, 1, 0);
                check(fifo_we && !fifo_word_done && fifo_wdata == w[15:0], "R5 opening write",
                      {fifo_we, fifo_word_done, 14'd0, fifo_wdata}, {2'b10, 14'd0, w[15:0]});
                check(ready_n == 1'b0, "R4 one half read", {31'd0, ready_n}, 32'd0);
                read_half(w, 1, 0, 1);
                check(fifo_we && fifo_word_done && fifo_wdata == w[31:16], "R6 closing write",
                      {fifo_we, fifo_word_done, 14'd0, fifo_wdata}, {2'b11, 14'd0, w[31:16]});
            end else begin
                read_half(w, (i % 3 == 1), 0, 0);
                check(ready_n == 1'b0, "R4 one half read", {31'd0, ready_n}, 32'd0);
                check(fifo_we == 1'b0, "R5 no write without load", {31'd0, fifo_we}, 32'd0);
                read_half(w, !(i % 3 == 1), 0, 0);
            end
            check(ready_n == 1'b1, "R4 both halves read", {31'd0, ready_n}, 32'd1);
            #1;
            check(bus_oe == 1'b0 && bus_data == 16'h0, "R3 bus idle",
                  {15'd0, bus_oe, bus_data}, 32'd0);
            check(order_err == 1'b0, "R7 no error in order", {31'd0, order_err}, 32'd0);
        end

        // R5: load strobes without rd_en ignored
        w = 32'hA5A5_3C3C;
        give_word(w);
        load_lo = 1; load_hi = 1;
        edge_step();
        idle();
        check(fifo_we == 1'b0 && order_err == 1'b0, "R5 loads without read ignored",
              {30'd0, fifo_we, order_err}, 32'd0);

        // R9: new word cancels pending opening half
        read_half(w, 0, 1, 0);
        check(fifo_we == 1'b1, "R9 opening write", {31'd0, fifo_we}, 32'd1);
        give_word(32'h1357_9BDF);
        read_half(32'h1357_9BDF, 1, 0, 1);
        check(fifo_we == 1'b0 && order_err == 1'b1, "R9 closing after new word",
              {30'd0, fifo_we, order_err}, 32'd1);

        // R8: master reset
        mreset = 1;
        edge_step();
        idle();
        check(ready_n == 1'b1 && order_err == 1'b0 && fifo_we == 1'b0, "R8 mreset flags",
              {29'd0, ready_n, order_err, fifo_we}, 32'd4);

        // R7: closing half first
        w = 32'h0F1E_2D3C;
        give_word(w);
        read_half(w, 1, 0, 1);
        check(fifo_we == 1'b0 && order_err == 1'b1, "R7 closing first",
              {30'd0, fifo_we, order_err}, 32'd1);
        edge_step();
        check(order_err == 1'b1, "R7 sticky", {31'd0, order_err}, 32'd1);

        // R7: both strobes at once
        mreset = 1; edge_step(); idle();
        give_word(w);
        read_half(w, 0, 1, 1);
        check(fifo_we == 1'b0 && order_err == 1'b1, "R7 both strobes",
              {30'd0, fifo_we, order_err}, 32'd1);

        // R8: mreset with word pending clears held word and pending half
        read_half(w, 0, 0, 0);
        mreset = 1; edge_step(); idle();
        check(ready_n == 1'b1, "R8 mreset drops word", {31'd0, ready_n}, 32'd1);
        read_half(32'h0, 1, 0, 0);
        read_half(32'h0, 0, 1, 0);
        mreset = 1; edge_step(); idle();
        read_half(32'h0, 1, 0, 1);
        check(fifo_we == 1'b0 && order_err == 1'b1, "R8 pending half dropped",
              {30'd0, fifo_we, order_err}, 32'd1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule